// File: doc/BRIEF.md
# Resumable Bit-Addressed Block Mover

The block copies a run of bits from one bit address to another through a single 16-bit word memory port. A command gives a source bit address, a destination bit address, a bit count, a cycle budget and a two-bit mode. Mode bit 1 permits a misaligned source, and mode bit 0 permits a misaligned destination. Each transfer step moves sixteen bits, or fewer on the last step. The source field may straddle two memory words, and it is shifted into place. Any destination word that is only partly covered is read, merged and written back, so bits outside the copied range keep their values.

Every transfer step costs part of the budget. When the budget runs out, the engine stops, writes its progress into three result registers (next source, next destination, bits still to move) and flags that the command must be reissued. Reissuing the command with the result values as the new operands resumes the copy where it stopped. The handshake is start, busy and a one-cycle done pulse. The error and restart flags are valid with done.

Top module: `blm_mover`

## Requirements
- R1: After reset, busy, done, restart, align_err, mem_rd and mem_wr are low, and res_src, res_dst and res_cnt are zero.
- R2: With both addresses aligned (low 4 bits zero), each step reads one word at source bit address >> 4 and writes it at destination bit address >> 4. Each step then advances both addresses by 16 and lowers the count by 16.
- R3: When fewer than 16 bits remain, one final step moves only those bits. Destination bits outside the copied range are left unchanged, and the remaining count becomes zero.
- R4: With mode bit 1 set, the source may sit at any bit offset. With mode bit 0 set, the destination may sit at any bit offset. The copy is still bit-exact when a field spans two words.
- R5: align_err is high with done if mode bit 1 is clear and the source has nonzero low 4 bits, or if mode bit 0 is clear and the destination has nonzero low 4 bits. The copy still takes place.
- R6: A step starts only while the remaining budget is nonzero, and each step lowers the budget by 2, stopping at zero. A budget B therefore allows at most ceil(B/2) steps, and a budget of 0 moves nothing.
- R7: At done, res_src, res_dst and res_cnt hold the next source, the next destination and the bits not yet moved. restart is high exactly when res_cnt is nonzero. Reissuing the command with these values completes the copy.
- R8: With mode bit 0 clear, res_src and res_dst hold the command's addresses for the whole time busy is high.
- R9: With mode bit 0 set, res_dst takes the new destination after every step while busy, and res_src holds the command's source until done.
- R10: done is a one-cycle pulse, and busy is low while done is high. A start while busy is ignored.
- R11: Memory reads return data in the same cycle as mem_rd. A word is written on the clock edge where mem_wr is high. The port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a command when idle |
| op_mode | input | 2 | Bit 1: source may be misaligned; bit 0: destination may be misaligned |
| cmd_src | input | 32 | Source bit address |
| cmd_dst | input | 32 | Destination bit address |
| cmd_cnt | input | 32 | Number of bits to move |
| cmd_budget | input | 16 | Cycle budget units |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Alignment violation of the last command |
| restart | output | 1 | Bits remain; reissue the command |
| res_src | output | 32 | Visible source result register |
| res_dst | output | 32 | Visible destination result register |
| res_cnt | output | 32 | Visible remaining-count register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 28 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, same cycle |

## Verification
The hardest case to reach is a copy that stops partway, because the budget ran out, when neither address is aligned. The resumed command must then start at an odd bit offset, and one field straddles two source words while the merge touches two destination words. The stimulus reaches this case by reissuing a long misaligned copy with a small budget until restart falls. Random commands also mix offsets, counts of up to a few hundred bits and budgets that are often too small. After every command, the bench compares the full memory image with a bit-level model.

// File: rtl/blm_pkg.sv
package blm_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_CHK, ST_SRD0, ST_SRD1, ST_DRD0, ST_DRD1,
      ST_DWR0, ST_DWR1, ST_ADV, ST_WB, ST_DONE
   } blm_state_e;
endpackage

// File: rtl/blm_step.sv
module blm_step #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 32,
   localparam int NW    = $clog2(WORD_W) + 1
) (
   input  logic [CNT_W-1:0]  cnt,
   output logic [NW-1:0]     n,
   output logic [WORD_W-1:0] mask
);
   assign n = (cnt >= CNT_W'(WORD_W)) ? NW'(WORD_W) : cnt[NW-1:0];

   for (genvar i = 0; i < WORD_W; i++) begin : g_mask
      assign mask[i] = (NW'(i) < n);
   end
endmodule

// File: rtl/blm_extract.sv
module blm_extract #(
   parameter int WORD_W = 16,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] lo,
   input  logic [WORD_W-1:0] hi,
   input  logic [OFF_W-1:0]  off,
   input  logic [WORD_W-1:0] mask,
   output logic [WORD_W-1:0] field
);
   logic [2*WORD_W-1:0] joined;
   assign joined = {hi, lo} >> off;
   assign field  = WORD_W'(joined) & mask;
endmodule

// File: rtl/blm_merge.sv
module blm_merge #(
   parameter int WORD_W = 16,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] old_lo,
   input  logic [WORD_W-1:0] old_hi,
   input  logic [WORD_W-1:0] field,
   input  logic [WORD_W-1:0] mask,
   input  logic [OFF_W-1:0]  off,
   output logic [WORD_W-1:0] new_lo,
   output logic [WORD_W-1:0] new_hi
);
   logic [2*WORD_W-1:0] m2, f2, res;
   assign m2  = {{WORD_W{1'b0}}, mask}  << off;
   assign f2  = {{WORD_W{1'b0}}, field} << off;
   assign res = ({old_hi, old_lo} & ~m2) | f2;
   assign new_lo = res[WORD_W-1:0];
   assign new_hi = res[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/blm_mover.sv
module blm_mover
   import blm_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 32,
   parameter int BUDGET_W    = 16,
   parameter int WORD_W      = 16,
   parameter int BUDGET_STEP = 2,
   localparam int OFF_W      = $clog2(WORD_W),
   localparam int NW         = OFF_W + 1,
   localparam int WA_W       = ADDR_W - OFF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          op_mode,
   input  logic [ADDR_W-1:0]   cmd_src,
   input  logic [ADDR_W-1:0]   cmd_dst,
   input  logic [CNT_W-1:0]    cmd_cnt,
   input  logic [BUDGET_W-1:0] cmd_budget,
   output logic                busy,
   output logic                done,
   output logic                align_err,
   output logic                restart,
   output logic [ADDR_W-1:0]   res_src,
   output logic [ADDR_W-1:0]   res_dst,
   output logic [CNT_W-1:0]    res_cnt,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic [WA_W-1:0]     mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   input  logic [WORD_W-1:0]   mem_rdata
);
   if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("blm_mover: WORD_W must be a power of two");
   end
   if (ADDR_W <= OFF_W || BUDGET_STEP < 1) begin : g_bad_cfg
      $error("blm_mover: bad address width or budget step");
   end

   blm_state_e           state;
   logic [ADDR_W-1:0]    src_q, dst_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [BUDGET_W-1:0]  bud_q;
   logic                 dtrack_q, busy_d;
   logic [WORD_W-1:0]    slo_q, shi_q, dlo_q, dhi_q;

   logic [NW-1:0]        n;
   logic [WORD_W-1:0]    mask, field, new_lo, new_hi;
   logic [OFF_W-1:0]     soff, doff;
   logic [NW-1:0]        s_end, d_end;
   logic                 s_span, d_span, d_full;
   logic [WA_W-1:0]      src_w, dst_w;

   assign soff   = src_q[OFF_W-1:0];
   assign doff   = dst_q[OFF_W-1:0];
   assign src_w  = src_q[ADDR_W-1:OFF_W];
   assign dst_w  = dst_q[ADDR_W-1:OFF_W];
   assign s_end  = NW'(soff) + n;
   assign d_end  = NW'(doff) + n;
   assign s_span = s_end > NW'(WORD_W);
   assign d_span = d_end > NW'(WORD_W);
   assign d_full = (doff == '0) && (n == NW'(WORD_W));

   blm_step #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_step (
      .cnt(cnt_q), .n(n), .mask(mask));

   blm_extract #(.WORD_W(WORD_W)) u_extract (
      .lo(slo_q), .hi(shi_q), .off(soff), .mask(mask), .field(field));

   blm_merge #(.WORD_W(WORD_W)) u_merge (
      .old_lo(dlo_q), .old_hi(dhi_q), .field(field), .mask(mask),
      .off(doff), .new_lo(new_lo), .new_hi(new_hi));

   assign busy = (state != ST_IDLE) && (state != ST_DONE);
   assign done = (state == ST_DONE);

   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         ST_SRD0: begin mem_rd = 1'b1; mem_addr = src_w; end
         ST_SRD1: begin mem_rd = 1'b1; mem_addr = src_w + WA_W'(1); end
         ST_DRD0: begin mem_rd = 1'b1; mem_addr = dst_w; end
         ST_DRD1: begin mem_rd = 1'b1; mem_addr = dst_w + WA_W'(1); end
         ST_DWR0: begin mem_wr = 1'b1; mem_addr = dst_w; mem_wdata = new_lo; end
         ST_DWR1: begin mem_wr = 1'b1; mem_addr = dst_w + WA_W'(1); mem_wdata = new_hi; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         src_q     <= '0;
         dst_q     <= '0;
         cnt_q     <= '0;
         bud_q     <= '0;
         dtrack_q  <= 1'b0;
         busy_d    <= 1'b0;
         slo_q     <= '0;
         shi_q     <= '0;
         dlo_q     <= '0;
         dhi_q     <= '0;
         align_err <= 1'b0;
         restart   <= 1'b0;
         res_src   <= '0;
         res_dst   <= '0;
         res_cnt   <= '0;
      end else begin
         busy_d <= busy;
         unique case (state)
            ST_IDLE, ST_DONE: if (start) begin
               src_q     <= cmd_src;
               dst_q     <= cmd_dst;
               cnt_q     <= cmd_cnt;
               bud_q     <= cmd_budget;
               dtrack_q  <= op_mode[0];
               res_src   <= cmd_src;
               res_dst   <= cmd_dst;
               res_cnt   <= cmd_cnt;
               restart   <= 1'b0;
               align_err <= (!op_mode[1] && cmd_src[OFF_W-1:0] != '0) ||
                            (!op_mode[0] && cmd_dst[OFF_W-1:0] != '0);
               state     <= ST_CHK;
            end else begin
               state <= ST_IDLE;
            end
            ST_CHK:  state <= (cnt_q == '0 || bud_q == '0) ? ST_WB : ST_SRD0;
            ST_SRD0: begin
               slo_q <= mem_rdata;
               state <= s_span ? ST_SRD1 : (d_full ? ST_DWR0 : ST_DRD0);
            end
            ST_SRD1: begin
               shi_q <= mem_rdata;
               state <= d_full ? ST_DWR0 : ST_DRD0;
            end
            ST_DRD0: begin
               dlo_q <= mem_rdata;
               state <= d_span ? ST_DRD1 : ST_DWR0;
            end
            ST_DRD1: begin
               dhi_q <= mem_rdata;
               state <= ST_DWR0;
            end
            ST_DWR0: state <= d_span ? ST_DWR1 : ST_ADV;
            ST_DWR1: state <= ST_ADV;
            ST_ADV: begin
               src_q <= src_q + ADDR_W'(n);
               dst_q <= dst_q + ADDR_W'(n);
               cnt_q <= cnt_q - CNT_W'(n);
               bud_q <= (bud_q > BUDGET_W'(BUDGET_STEP)) ?
                        bud_q - BUDGET_W'(BUDGET_STEP) : '0;
               if (dtrack_q) res_dst <= dst_q + ADDR_W'(n);
               state <= ST_CHK;
            end
            ST_WB: begin
               res_src <= src_q;
               res_dst <= dst_q;
               res_cnt <= cnt_q;
               restart <= (cnt_q != '0);
               state   <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: completion is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: restart agrees with the written-back count
   a_r7_restart_matches: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (restart == (res_cnt != '0)));
   // R8: addresses held while busy when destination tracking is off
   a_r8_regs_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_d && !dtrack_q) |-> ($stable(res_src) && $stable(res_dst)));
   // R9: source register never moves during the operation
   a_r9_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_d) |-> $stable(res_src));
   // R11: memory is only touched inside a command, one access per cycle
   a_r11_port_use: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (busy && !(mem_rd && mem_wr)));
endmodule

// File: tb/tb_blm_mover.sv
module tb_blm_mover;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_mode = '0;
   logic [31:0] cmd_src = '0, cmd_dst = '0, cmd_cnt = '0;
   logic [15:0] cmd_budget = '0;
   logic        busy, done, align_err, restart;
   logic [31:0] res_src, res_dst, res_cnt;
   logic        mem_rd, mem_wr;
   logic [27:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;

   logic [15:0] mem     [256];
   logic [15:0] exp_mem [256];

   int checks = 0;
   int fails  = 0;
   logic [31:0] seed_junk;

   always #(CLK_PERIOD/2) clk = ~clk;

   blm_mover dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode),
      .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_cnt(cmd_cnt),
      .cmd_budget(cmd_budget), .busy(busy), .done(done),
      .align_err(align_err), .restart(restart), .res_src(res_src),
      .res_dst(res_dst), .res_cnt(res_cnt), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata));

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int steps_allowed(int cnt, int bud);
      int t_bud, t_cnt;
      t_bud = (bud + 1) / 2;
      t_cnt = (cnt + 15) / 16;
      return (t_bud < t_cnt) ? t_bud : t_cnt;
   endfunction

   task automatic model_copy(int s, int d, int nbits);
      for (int i = 0; i < nbits; i++)
         exp_mem[(d + i) >> 4][(d + i) & 15] = exp_mem[(s + i) >> 4][(s + i) & 15];
   endtask

   task automatic run_cmd(input logic [1:0] op, input int s, input int d,
                          input int cnt, input int bud, input bit intrude);
      int cycles = 0, changes = 0, bad_fixed = 0, steps, moved, bad_words = 0;
      bit have_prev = 0, exp_err;
      logic [31:0] prev = '0;
      steps = steps_allowed(cnt, bud);
      moved = (16 * steps < cnt) ? 16 * steps : cnt;
      exp_err = (!op[1] && (s & 15) != 0) || (!op[0] && (d & 15) != 0);
      @(negedge clk);
      op_mode = op; cmd_src = s; cmd_dst = d; cmd_cnt = cnt; cmd_budget = bud[15:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cycles < 4000) begin
         if (busy) begin
            if (res_src != s) bad_fixed++;
            if (!op[0] && res_dst != d) bad_fixed++;
            if (have_prev && res_dst != prev) changes++;
            prev = res_dst; have_prev = 1;
         end
         if (intrude && cycles == 3) begin
            start = 1'b1; cmd_src = 32'd16; cmd_dst = 32'd2048; cmd_cnt = 32'd16;
            op_mode = 2'b11;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cycles++;
      end
      start = 1'b0;
      chk(done, "R10 completion seen", done, 1);
      chk(!busy, "R10 busy low with done", busy, 0);
      chk(res_src == s + moved, "R2/R7 res_src", res_src, s + moved);
      chk(res_dst == d + moved, "R2/R7 res_dst", res_dst, d + moved);
      chk(res_cnt == cnt - moved, "R3/R6/R7 res_cnt", res_cnt, cnt - moved);
      chk(restart == (cnt != moved), "R7 restart", restart, cnt != moved);
      chk(align_err == exp_err, "R5 align_err", align_err, exp_err);
      chk(bad_fixed == 0, "R8/R9 fixed registers", bad_fixed, 0);
      chk(changes == (op[0] ? steps : 0), "R9 res_dst tracking", changes, op[0] ? steps : 0);
      model_copy(s, d, moved);
      for (int w = 0; w < 256; w++) if (mem[w] != exp_mem[w]) bad_words++;
      chk(bad_words == 0, "R2/R3/R4/R11 memory image", bad_words, 0);
      @(negedge clk);
      chk(!done, "R10 done pulse width", done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int s, d, c, guard;
      seed_junk = $urandom(32'd4711);
      for (int w = 0; w < 256; w++) begin
         mem[w] = 16'($urandom);
         exp_mem[w] = mem[w];
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !restart && !align_err, "R1 flags", {busy, done, restart, align_err}, 0);
      chk(!mem_rd && !mem_wr, "R1 memory strobes", {mem_rd, mem_wr}, 0);
      chk(res_src == 0 && res_dst == 0 && res_cnt == 0, "R1 result registers", res_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_cmd(2'b00, 32, 2048, 64, 100, 0);          // R2 aligned words
      run_cmd(2'b00, 64, 2048 + 80, 7, 10, 0);       // R3 partial RMW
      run_cmd(2'b11, 5, 2048 + 200 + 11, 45, 20, 0); // R4 both misaligned
      run_cmd(2'b00, 3, 2400, 20, 10, 0);            // R5 src misaligned, S clear
      run_cmd(2'b10, 96, 2500 + 7, 30, 10, 0);       // R5 dst misaligned, D clear
      run_cmd(2'b01, 131, 2600, 18, 10, 0);          // R5 src misaligned, D only
      run_cmd(2'b11, 160, 2700, 50, 0, 0);           // R6 zero budget
      run_cmd(2'b00, 160, 2800, 80, 3, 0);           // R6 odd budget: 2 steps
      run_cmd(2'b01, 400, 3000, 160, 100, 1);        // R9/R10 start while busy

      // R7: resume a misaligned copy with a tiny budget until done
      s = 613; d = 3300 + 9; c = 211; guard = 0;
      do begin
         run_cmd(2'b11, s, d, c, 4, 0);
         s = res_src; d = res_dst; c = res_cnt; guard++;
      end while (restart && guard < 40);
      chk(c == 0, "R7 resumed copy finished", c, 0);

      for (int k = 0; k < 30; k++) begin
         logic [1:0] op;
         op = 2'($urandom);
         run_cmd(op, int'($urandom % 1500), 2048 + int'($urandom % 1650),
                 int'($urandom % 300), int'($urandom % 41), 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule